// File: doc/BRIEF.md
# Scheduled Sub-Step Digital Output Generator

This block drives a bank of digital output lines whose edges are placed on individual fine ticks inside a fixed-length simulation step, rather than being updated once per step. A free-running tick counter divides time into steps of `STEP_TICKS` ticks (a 100 MHz tick and a 1000-tick step give 10 ns placement in a 10 µs step). While one step runs, the host fills a shadow list with up to `SLOTS` timed entries, each naming a tick offset, a channel and the new level. It then commits the list.

At the next step boundary the committed list becomes the active schedule. Each active entry drives its channel to its level at its offset. Two complementary edges can therefore be a few ticks apart, which models dead times far shorter than a step. If the host has not committed by the boundary, the step runs with no entries and a late flag is raised for that whole step. Entries whose offset does not fit inside a step are refused and reported.

Top module: `subtick_dout`

## Requirements
- R1: While reset is held, and in the first cycle after it is released:
  - `dout_o` equals the parameter `DEF_LEVEL`.
  - `late_load_o` and `bad_entry_o` are 0.
  - `step_tick_o` is 0.
  - The active and shadow schedules are empty.
- R2: `step_tick_o` advances by one every clock, counting from 0 up to `STEP_TICKS-1`. The cycle after `STEP_TICKS-1` reads 0, and that wrap is the step boundary.
- R3: An active entry with offset k drives bit `chan` of `dout_o` to its level in the cycle where `step_tick_o` is k+1. For k = `STEP_TICKS-1` this is tick 0 of the following step.
- R4: Entries written and committed during one step take effect only in the next step. They have no effect on the outputs of the step in which they were written.
- R5: Several entries may share an offset. All of them apply in that tick, in write order, so on a shared channel the entry written last sets the level.
- R6: A write whose offset is `STEP_TICKS` or more is not stored and uses no slot. It raises `bad_entry_o` for exactly the next cycle. Every other write leaves `bad_entry_o` at 0.
- R7: If no commit has been registered when the boundary is reached:
  - The new step has an empty active schedule.
  - `late_load_o` is 1 for that whole step.
  - Uncommitted shadow entries are discarded.
  When a commit has been registered, `late_load_o` is 0 for the new step.
- R8: A channel that no entry touches holds its level, both across ticks and across steps.
- R9: The shadow list ignores two kinds of write:
  - any write beyond the `SLOTS`-th accepted write of a step;
  - any write made after the commit and before the boundary.
- R10: A write or commit presented in the boundary cycle (`step_tick_o` = `STEP_TICKS-1`) belongs to the freshly emptied shadow list. A commit in that cycle therefore makes the following step late, and its entries run in the step after that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Tick clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en_i | input | 1 | Append one entry to the shadow list |
| wr_offset_i | input | OFF_W | Tick offset of the entry within the step |
| wr_chan_i | input | CH_W | Output channel of the entry |
| wr_level_i | input | 1 | Level the channel takes at the offset |
| commit_i | input | 1 | Mark the shadow list ready for the next boundary |
| step_tick_o | output | OFF_W | Current tick within the step |
| late_load_o | output | 1 | The current step started without a committed schedule |
| bad_entry_o | output | 1 | The write of the previous cycle had an out-of-step offset |
| dout_o | output | N_CH | Scheduled digital outputs |

## Verification
The bench targets five corner cases:
- Entries at the last tick of a step, where a design that swapped schedules one cycle early would lose the edge or apply it with the new list.
- Duplicate offsets on one channel, where the wrong priority leaves the first-written level on the line.
- A commit made in the boundary cycle itself, which a design that sampled the commit combinationally would wrongly apply one step early without flagging late.
- Overfull lists, writes after a commit, and out-of-range offsets. A careless design would store these, corrupt a slot or fire spurious edges.
- Missed commits, where the outputs must hold and the flag must stay high for exactly one step.

// File: rtl/sdo_pkg.sv
// Shared helpers for the scheduled sub-step digital output block.
// Assumes: widths are derived from elaboration-time parameters only.
package sdo_pkg;
    // Bits needed to hold values 0..n (at least one bit).
    function automatic int bits_for(input int n);
        return (n < 2) ? 1 : $clog2(n + 1);
    endfunction
endpackage

// File: rtl/sdo_step_timer.sv
// Step timer: counts ticks 0..STEP_TICKS-1 and flags the last tick of each step.
// Assumes: every clock is one fine tick; STEP_TICKS >= 2.
module sdo_step_timer #(
    parameter int STEP_TICKS = 1000,
    parameter int OFF_W      = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [OFF_W-1:0] tick_o,
    output logic             boundary_o
);
    localparam logic [OFF_W-1:0] LAST = OFF_W'(STEP_TICKS - 1);

    logic [OFF_W-1:0] cnt_q;

    assign boundary_o = (cnt_q == LAST);
    assign tick_o     = cnt_q;

    // Advance the in-step tick and wrap at the step boundary.
    always_ff @(posedge clk) begin
        if (!rst_n)          cnt_q <= '0;
        else if (boundary_o) cnt_q <= '0;
        else                 cnt_q <= cnt_q + 1'b1;
    end

    a_r2_tick_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST);
    a_r2_wrap_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
        boundary_o |=> cnt_q == '0);
endmodule

// File: rtl/sdo_sched_buf.sv
// Double-buffered schedule: a shadow list filled by the host and an active list
// swapped in at each step boundary, if committed; otherwise the active list is emptied.
// Assumes: SLOTS >= 2; writes and commit in the boundary cycle go to the emptied shadow.
module sdo_sched_buf #(
    parameter int STEP_TICKS = 1000,
    parameter int SLOTS      = 4,
    parameter int OFF_W      = 11,
    parameter int CH_W       = 3
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        boundary_i,
    input  logic                        wr_en_i,
    input  logic [OFF_W-1:0]            wr_off_i,
    input  logic [CH_W-1:0]             wr_ch_i,
    input  logic                        wr_lvl_i,
    input  logic                        commit_i,
    output logic [SLOTS-1:0]            act_vld_o,
    output logic [SLOTS-1:0][OFF_W-1:0] act_off_o,
    output logic [SLOTS-1:0][CH_W-1:0]  act_ch_o,
    output logic [SLOTS-1:0]            act_lvl_o,
    output logic                        late_o,
    output logic                        bad_o
);
    localparam int SLOT_W = sdo_pkg::bits_for(SLOTS);
    localparam int IDX_W  = $clog2(SLOTS);

    logic [SLOTS-1:0][OFF_W-1:0] sh_off_q;
    logic [SLOTS-1:0][CH_W-1:0]  sh_ch_q;
    logic [SLOTS-1:0]            sh_lvl_q;
    logic [SLOT_W-1:0]           sh_cnt_q;
    logic                        cm_q;
    logic                        late_q;
    logic                        bad_q;

    logic [SLOT_W-1:0] base_cnt;
    logic              base_cm;
    logic              off_ok;
    logic              accept;
    logic [IDX_W-1:0]  wr_idx;

    // Shadow state as seen by this cycle's write, after any boundary clear.
    always_comb begin
        base_cnt = boundary_i ? '0 : sh_cnt_q;
        base_cm  = boundary_i ? 1'b0 : cm_q;
        off_ok   = (wr_off_i < OFF_W'(STEP_TICKS));
        accept   = wr_en_i && off_ok && !base_cm && (base_cnt < SLOT_W'(SLOTS));
        wr_idx   = base_cnt[IDX_W-1:0];
    end

    // Swap or empty the active list at the boundary, then append to the shadow list.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_off_q  <= '0;
            sh_ch_q   <= '0;
            sh_lvl_q  <= '0;
            sh_cnt_q  <= '0;
            cm_q      <= 1'b0;
            act_vld_o <= '0;
            act_off_o <= '0;
            act_ch_o  <= '0;
            act_lvl_o <= '0;
            late_q    <= 1'b0;
            bad_q     <= 1'b0;
        end else begin
            if (boundary_i) begin
                for (int i = 0; i < SLOTS; i++)
                    act_vld_o[i] <= cm_q && (SLOT_W'(i) < sh_cnt_q);
                act_off_o <= sh_off_q;
                act_ch_o  <= sh_ch_q;
                act_lvl_o <= sh_lvl_q;
                late_q    <= !cm_q;
            end
            if (accept) begin
                sh_off_q[wr_idx] <= wr_off_i;
                sh_ch_q[wr_idx]  <= wr_ch_i;
                sh_lvl_q[wr_idx] <= wr_lvl_i;
            end
            sh_cnt_q <= base_cnt + SLOT_W'(accept);
            cm_q     <= base_cm | commit_i;
            bad_q    <= wr_en_i && !off_ok;
        end
    end

    assign late_o = late_q;
    assign bad_o  = bad_q;

    a_r9_slot_cap: assert property (@(posedge clk) disable iff (!rst_n)
        sh_cnt_q <= SLOT_W'(SLOTS));
    a_r7_late_empty: assert property (@(posedge clk) disable iff (!rst_n)
        boundary_i && !cm_q |=> late_q && act_vld_o == '0);
    a_r4_commit_loads: assert property (@(posedge clk) disable iff (!rst_n)
        boundary_i && cm_q |=> !late_q);
    a_r6_bad_not_stored: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_i && !off_ok && !boundary_i |=> sh_cnt_q == $past(sh_cnt_q) && bad_q);
endmodule

// File: rtl/sdo_apply.sv
// Compare/apply stage: drives each output to the level of any active entry whose
// offset equals the current tick; entries apply in slot (write) order.
// Assumes: channel numbers at or above N_CH never match.
module sdo_apply #(
    parameter int                N_CH      = 8,
    parameter int                SLOTS     = 4,
    parameter int                OFF_W     = 11,
    parameter int                CH_W      = 3,
    parameter logic [N_CH-1:0]   DEF_LEVEL = '0
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [OFF_W-1:0]            tick_i,
    input  logic [SLOTS-1:0]            act_vld_i,
    input  logic [SLOTS-1:0][OFF_W-1:0] act_off_i,
    input  logic [SLOTS-1:0][CH_W-1:0]  act_ch_i,
    input  logic [SLOTS-1:0]            act_lvl_i,
    output logic [N_CH-1:0]             dout_o
);
    logic [N_CH-1:0] dout_q;
    logic [N_CH-1:0] nxt;
    logic [SLOTS-1:0] hit;

    // Per-slot match of the current tick against a valid in-range entry.
    always_comb begin
        for (int i = 0; i < SLOTS; i++)
            hit[i] = act_vld_i[i] && (act_off_i[i] == tick_i) && (int'(act_ch_i[i]) < N_CH);
    end

    // Fold matching entries into the next output word; later slots override.
    always_comb begin
        nxt = dout_q;
        for (int i = 0; i < SLOTS; i++)
            if (hit[i]) nxt[act_ch_i[i]] = act_lvl_i[i];
    end

    // Register the outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) dout_q <= DEF_LEVEL;
        else        dout_q <= nxt;
    end

    assign dout_o = dout_q;

    a_r8_hold_without_hit: assert property (@(posedge clk) disable iff (!rst_n)
        hit == '0 |=> dout_q == $past(dout_q));
    a_r1_reset_level: assert property (@(posedge clk)
        !rst_n |=> dout_q == DEF_LEVEL);
endmodule

// File: rtl/subtick_dout.sv
// Top of the scheduled sub-step digital output generator: step timer, double-
// buffered schedule and compare/apply stage.
// Assumes: one fine tick per clock; host writes at most SLOTS entries per step.
module subtick_dout #(
    parameter int              N_CH       = 8,
    parameter int              STEP_TICKS = 1000,
    parameter int              SLOTS      = 4,
    parameter logic [N_CH-1:0] DEF_LEVEL  = '0,
    parameter int              OFF_W      = $clog2(STEP_TICKS) + 1,
    parameter int              CH_W       = (N_CH > 1) ? $clog2(N_CH) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en_i,
    input  logic [OFF_W-1:0] wr_offset_i,
    input  logic [CH_W-1:0]  wr_chan_i,
    input  logic             wr_level_i,
    input  logic             commit_i,
    output logic [OFF_W-1:0] step_tick_o,
    output logic             late_load_o,
    output logic             bad_entry_o,
    output logic [N_CH-1:0]  dout_o
);
    logic                        boundary;
    logic [SLOTS-1:0]            act_vld;
    logic [SLOTS-1:0][OFF_W-1:0] act_off;
    logic [SLOTS-1:0][CH_W-1:0]  act_ch;
    logic [SLOTS-1:0]            act_lvl;

    sdo_step_timer #(.STEP_TICKS(STEP_TICKS), .OFF_W(OFF_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .tick_o(step_tick_o), .boundary_o(boundary));

    sdo_sched_buf #(.STEP_TICKS(STEP_TICKS), .SLOTS(SLOTS), .OFF_W(OFF_W), .CH_W(CH_W)) u_buf (
        .clk(clk), .rst_n(rst_n), .boundary_i(boundary),
        .wr_en_i(wr_en_i), .wr_off_i(wr_offset_i), .wr_ch_i(wr_chan_i),
        .wr_lvl_i(wr_level_i), .commit_i(commit_i),
        .act_vld_o(act_vld), .act_off_o(act_off), .act_ch_o(act_ch), .act_lvl_o(act_lvl),
        .late_o(late_load_o), .bad_o(bad_entry_o));

    sdo_apply #(.N_CH(N_CH), .SLOTS(SLOTS), .OFF_W(OFF_W), .CH_W(CH_W), .DEF_LEVEL(DEF_LEVEL)) u_apply (
        .clk(clk), .rst_n(rst_n), .tick_i(step_tick_o),
        .act_vld_i(act_vld), .act_off_i(act_off), .act_ch_i(act_ch), .act_lvl_i(act_lvl),
        .dout_o(dout_o));
endmodule

// File: tb/test_subtick_dout.sv
module test_subtick_dout;
    localparam int       STEP = 100;
    localparam int       NCH  = 8;
    localparam int       SL   = 4;
    localparam int       OW   = $clog2(STEP) + 1;
    localparam int       CW   = 3;
    localparam logic [7:0] DEF = 8'hA5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_en = 1'b0, wr_lvl = 1'b0, commit = 1'b0;
    logic [OW-1:0] wr_off = '0;
    logic [CW-1:0] wr_ch = '0;
    logic [OW-1:0] tick;
    logic late, bad;
    logic [NCH-1:0] dout;

    always #4 clk = ~clk;

    subtick_dout #(.N_CH(NCH), .STEP_TICKS(STEP), .SLOTS(SL), .DEF_LEVEL(DEF)) i_subtick_dout (
        .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .wr_offset_i(wr_off), .wr_chan_i(wr_ch),
        .wr_level_i(wr_lvl), .commit_i(commit), .step_tick_o(tick), .late_load_o(late),
        .bad_entry_o(bad), .dout_o(dout));

    int checks = 0, failures = 0;
    bit done = 0;

    // Reference state built from the requirements.
    int sh_off[SL], sh_ch[SL], sh_lvl[SL], sh_n;
    int ac_off[SL], ac_ch[SL], ac_lvl[SL], ac_n;
    bit sh_cm;
    int e_tick;
    bit e_late, e_bad;
    logic [NCH-1:0] e_dout;

    task automatic check(input string tag, input int got, input int exp);
        checks++;
        if (got != exp) begin
            failures++;
            $display("FAIL %s got=%0h exp=%0h at t=%0t", tag, got, exp, $time);
        end
    endtask

    task automatic model_reset();
        sh_n = 0; ac_n = 0; sh_cm = 0;
        e_tick = 0; e_late = 0; e_bad = 0; e_dout = DEF;
    endtask

    // One clock edge of the expected behaviour (R2..R10).
    task automatic model_edge(input bit w, input int off, input int ch, input int lvl, input bit cm);
        bit bnd;
        for (int i = 0; i < ac_n; i++)
            if (ac_off[i] == e_tick) e_dout[ac_ch[i]] = lvl_bit(ac_lvl[i]);
        e_bad = w && (off >= STEP);
        bnd = (e_tick == STEP - 1);
        if (bnd) begin
            if (sh_cm) begin
                ac_n = sh_n;
                for (int i = 0; i < SL; i++) begin
                    ac_off[i] = sh_off[i]; ac_ch[i] = sh_ch[i]; ac_lvl[i] = sh_lvl[i];
                end
                e_late = 0;
            end else begin
                ac_n = 0; e_late = 1;
            end
            sh_n = 0; sh_cm = 0;
        end
        if (w && off < STEP && !sh_cm && sh_n < SL) begin
            sh_off[sh_n] = off; sh_ch[sh_n] = ch; sh_lvl[sh_n] = lvl; sh_n++;
        end
        if (cm) sh_cm = 1;
        e_tick = bnd ? 0 : e_tick + 1;
    endtask

    function automatic bit lvl_bit(input int v);
        return v != 0;
    endfunction

    task automatic compare_all();
        check("R2 step_tick", int'(tick), e_tick);
        check("R3 dout", int'(dout), int'(e_dout));
        check("R7 late_load", int'(late), int'(e_late));
        check("R6 bad_entry", int'(bad), int'(e_bad));
    endtask

    // Drive one cycle of inputs, advance the model with them, compare away from the edge.
    task automatic cyc(input bit w, input int off, input int ch, input int lvl, input bit cm);
        wr_en = w; wr_off = OW'(off); wr_ch = CW'(ch); wr_lvl = lvl_bit(lvl); commit = cm;
        @(posedge clk);
        model_edge(w, off, ch, lvl, cm);
        @(negedge clk);
        wr_en = 0; commit = 0;
        compare_all();
    endtask

    task automatic run_to(input int t);
        while (e_tick != t) cyc(0, 0, 0, 0, 0);
    endtask

    initial begin
        void'($urandom(32'd20250611));
        model_reset();
        repeat (3) @(negedge clk);
        check("R1 reset dout", int'(dout), int'(DEF));
        check("R1 reset late", int'(late), 0);
        check("R1 reset tick", int'(tick), 0);
        rst_n = 1'b1;
        check("R1 first cycle dout", int'(dout), int'(DEF));
        check("R1 first cycle bad", int'(bad), 0);

        // Step 0: directed schedule for step 1.
        cyc(1, 5, 1, 0, 0);
        cyc(1, 5, 1, 1, 0);            // same offset, same channel: later wins (R5)
        cyc(1, 5, 2, 0, 0);            // same offset, other channel
        cyc(1, 120, 0, 0, 0);          // out of range (R6)
        check("R6 bad pulse", int'(bad), 1);
        cyc(1, 99, 3, 1, 0);           // last tick edge (R3)
        cyc(1, 10, 4, 1, 0);           // fifth accepted write: dropped (R9)
        cyc(0, 0, 0, 0, 1);
        cyc(1, 11, 5, 0, 0);           // after commit: dropped (R9)
        run_to(50);
        check("R4 no effect in writing step", int'(dout), int'(DEF));
        run_to(0);
        check("R4 committed step not late", int'(late), 0);
        run_to(6);
        check("R5 later entry wins ch1", int'(dout[1]), 1);
        check("R5 shared offset ch2", int'(dout[2]), 0);
        check("R9 overflow entry absent ch4", int'(dout[4]), 0);
        run_to(12);
        check("R9 post-commit entry absent ch5", int'(dout[5]), 1);
        check("R8 untouched ch7 holds", int'(dout[7]), 1);
        // No commit in step 1: uncommitted write is discarded.
        cyc(1, 30, 6, 1, 0);
        run_to(0);
        check("R3 last-tick edge lands at tick 0", int'(dout[3]), 1);
        check("R7 late after missed commit", int'(late), 1);
        run_to(40);
        check("R7 discarded entry ch6", int'(dout[6]), 0);
        check("R8 outputs hold in empty step", int'(dout), 8'hAB);
        // R10: write and commit in the boundary cycle of step 2.
        run_to(STEP - 1);
        cyc(1, 3, 0, 0, 1);
        check("R10 boundary commit makes step late", int'(late), 1);
        run_to(10);
        check("R10 entry not yet applied", int'(dout[0]), 1);
        run_to(0);
        check("R10 following step not late", int'(late), 0);
        run_to(4);
        check("R10 entry applied two steps on", int'(dout[0]), 0);

        // Random phase.
        for (int s = 0; s < 150; s++) begin
            int ctick;
            ctick = ($urandom % 10 == 0) ? -1 : int'($urandom % STEP);
            for (int t = 0; t < STEP; t++) begin
                bit w;
                w = ($urandom % 12) == 0;
                cyc(w, int'($urandom % 128), int'($urandom % NCH), int'($urandom % 2),
                    (e_tick == ctick));
            end
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule